// File: doc/BRIEF.md
# Oversampling Serial Receiver with Majority Voting

This block receives asynchronous serial characters from a single line that is sampled on a strobe running at sixteen times the bit rate. Each strobe is one RT slot. The receiver stays idle until it sees a high-to-low transition on the line. It then confirms the start bit with three extra samples. After that it reads the data bits and the stop bit by voting on three samples near the middle of each bit. All bit timing comes from the detected start edge, so the receiver needs no timing from the transmitter.

Every received character appears on a parallel word together with a one-cycle valid strobe. Two flags accompany the strobe. The noise flag reports that some vote was not unanimous. The framing flag reports a stop bit that voted low. A select input chooses a frame of eight or nine data bits. The bit-rate strobe comes from outside the block.

Top module: `ovs_uart_rx`

## Requirements
- R1: After reset, the data word, the valid strobe and both flags are zero. A falling edge is accepted only after the line has been sampled high on a strobe since reset, so a line that is low from reset does not start a frame.
- R2: A strobe that samples the line low, when the previous strobe sampled it high, is RT slot 1 of a start bit. The line is then sampled at slots 3, 5 and 7. The start bit is accepted when at least two of those samples are low. Otherwise the receiver returns to idle and delivers nothing.
- R3: If an accepted start bit had any of its slot 3, 5 or 7 samples high, that character is delivered with the noise flag set.
- R4: The value of each data bit and of the stop bit is the majority of its samples at RT slots 8, 9 and 10. Line values at other slots of those bits have no effect on the output.
- R5: The noise flag is set for a character when the three centre samples of its start bit, of any data bit, or of its stop bit are not all equal.
- R6: Data bits arrive least significant first. Output bit k holds the k-th received data bit. In 8-bit frames, output bit 8 is zero.
- R7: The frame-length select is read only on the strobe that begins the start bit (1 = nine data bits, 0 = eight). Changes to it later in the frame have no effect.
- R8: The valid strobe is high for exactly one clock, in the cycle after the clock edge that samples RT slot 10 of the stop bit. The data word holds its value until the next delivery.
- R9: The noise and framing flags describe only the character just delivered. They are zero whenever the valid strobe is low.
- R10: A stop bit that votes low sets the framing flag, and the character is still delivered with the valid strobe.
- R11: After slot 10 of the stop bit, the receiver is idle. Back-to-back frames with no idle gap are received. A line that stays low after a low stop bit starts no frame until it has been sampled high again.
- R12: The receiver advances only on clocks where the bit-rate strobe is high. The valid strobe never rises unless the previous clock carried a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16_i | input | 1 | Sample strobe at sixteen times the bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| long_frame_i | input | 1 | 1 selects nine data bits, 0 selects eight |
| rx_data_o | output | LONG_BITS | Received data word, LSB first on the line |
| rx_valid_o | output | 1 | One-cycle strobe for a delivered character |
| rx_noise_o | output | 1 | A vote of this character was not unanimous |
| rx_ferr_o | output | 1 | The stop bit of this character voted low |

## Verification
The bench goes after several corner cases.

Single-slot glitches at slots 3, 8, 9 and 10 must raise the noise flag without changing any bit. A design that voted on one sample would deliver wrong data, and one that ignored the verification samples would miss the flag. Glitches at slots 2, 6 and 12 must have no effect, which catches a design that samples outside the bit centre.

Short low pulses and a start pattern with two high verification samples must produce nothing. A receiver that does not reject these would deliver ghost characters. The frame-length select is flipped right after the start edge, so a design that reads it late would deliver the wrong number of bits.

A low stop bit followed by a long low stretch checks that the character is still delivered. It also checks that the receiver does not restart on a level instead of an edge. Back-to-back frames check that the receiver re-arms at slot 10 and does not wait out the whole stop bit.

// File: rtl/ovs_rx_pkg.sv
package ovs_rx_pkg;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_DATA  = 2'd2,
      RX_STOP  = 2'd3
   } rx_state_e;

   localparam int VOTE_N = 3;

endpackage

// File: rtl/ovs_rx_vote.sv
module ovs_rx_vote
   import ovs_rx_pkg::*;
(
   input  logic [VOTE_N-1:0] smp_i,
   output logic              maj_o,
   output logic              mixed_o
);

   always_comb begin
      maj_o   = (smp_i[0] & smp_i[1]) | (smp_i[0] & smp_i[2]) | (smp_i[1] & smp_i[2]);
      mixed_o = (|smp_i) & ~(&smp_i);
   end

endmodule

// File: rtl/ovs_rx_seq.sv
module ovs_rx_seq
   import ovs_rx_pkg::*;
#(
   parameter int OSR        = 16,
   parameter int VER_A      = 3,
   parameter int VER_B      = 5,
   parameter int VER_C      = 7,
   parameter int CTR_SLOT   = 8,
   parameter int SHORT_BITS = 8,
   parameter int LONG_BITS  = 9
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick_i,
   input  logic                 rxd_i,
   input  logic                 long_i,
   output logic [VOTE_N-1:0]    ver_set_o,
   output logic [VOTE_N-1:0]    ctr_set_o,
   input  logic                 ver_maj_i,
   input  logic                 ver_mixed_i,
   input  logic                 ctr_maj_i,
   input  logic                 ctr_mixed_i,
   output logic [LONG_BITS-1:0] data_o,
   output logic                 valid_o,
   output logic                 noise_o,
   output logic                 ferr_o
);

   localparam int RTW    = $clog2(OSR + 1);
   localparam int BIW    = (LONG_BITS > 1) ? $clog2(LONG_BITS) : 1;
   localparam int CTR_B  = CTR_SLOT + 1;
   localparam int CTR_C  = CTR_SLOT + 2;

   if (OSR < CTR_C)
      $error("ovs_rx_seq: OSR must cover the centre slots");
   if (!(VER_A < VER_B && VER_B < VER_C && VER_C < CTR_SLOT && VER_A > 1))
      $error("ovs_rx_seq: verification slots must ascend between slot 2 and the centre");
   if (SHORT_BITS < 1 || LONG_BITS < SHORT_BITS)
      $error("ovs_rx_seq: frame lengths out of order");

   rx_state_e            state;
   logic                 prev_s;
   logic [RTW-1:0]       rt, cur;
   logic [BIW-1:0]       bit_i, last_i, last_sel;
   logic [1:0]           vs, cs;
   logic                 noise_acc;
   logic [LONG_BITS-1:0] shreg;

   generate
      if (LONG_BITS > SHORT_BITS) begin : g_two_len
         assign last_sel = long_i ? BIW'(LONG_BITS - 1) : BIW'(SHORT_BITS - 1);
      end else begin : g_one_len
         logic unused_long;
         assign unused_long = long_i;
         assign last_sel    = BIW'(SHORT_BITS - 1);
      end
   endgenerate

   always_comb begin
      cur       = (rt == RTW'(OSR)) ? RTW'(1) : rt + RTW'(1);
      ver_set_o = {rxd_i, vs};
      ctr_set_o = {rxd_i, cs};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_IDLE;
         prev_s    <= 1'b0;
         rt        <= '0;
         bit_i     <= '0;
         last_i    <= '0;
         vs        <= '0;
         cs        <= '0;
         noise_acc <= 1'b0;
         shreg     <= '0;
         data_o    <= '0;
         valid_o   <= 1'b0;
         noise_o   <= 1'b0;
         ferr_o    <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         noise_o <= 1'b0;
         ferr_o  <= 1'b0;
         if (tick_i) begin
            prev_s <= rxd_i;
            if (state == RX_IDLE) begin
               if (prev_s && !rxd_i) begin
                  state     <= RX_START;
                  rt        <= RTW'(1);
                  bit_i     <= '0;
                  last_i    <= last_sel;
                  noise_acc <= 1'b0;
                  shreg     <= '0;
               end
            end else begin
               rt <= cur;
               if (cur == RTW'(VER_A))    vs[0] <= rxd_i;
               if (cur == RTW'(VER_B))    vs[1] <= rxd_i;
               if (cur == RTW'(CTR_SLOT)) cs[0] <= rxd_i;
               if (cur == RTW'(CTR_B))    cs[1] <= rxd_i;
               unique case (state)
                  RX_START: begin
                     if (cur == RTW'(VER_C)) begin
                        if (ver_maj_i) state <= RX_IDLE;
                        else noise_acc <= noise_acc | ver_mixed_i;
                     end
                     if (cur == RTW'(CTR_C)) noise_acc <= noise_acc | ctr_mixed_i;
                     if (cur == RTW'(OSR))   state <= RX_DATA;
                  end
                  RX_DATA: begin
                     if (cur == RTW'(CTR_C)) begin
                        shreg[bit_i] <= ctr_maj_i;
                        noise_acc    <= noise_acc | ctr_mixed_i;
                     end
                     if (cur == RTW'(OSR)) begin
                        if (bit_i == last_i) state <= RX_STOP;
                        else bit_i <= bit_i + BIW'(1);
                     end
                  end
                  RX_STOP: begin
                     if (cur == RTW'(CTR_C)) begin
                        valid_o <= 1'b1;
                        data_o  <= shreg;
                        noise_o <= noise_acc | ctr_mixed_i;
                        ferr_o  <= ~ctr_maj_i;
                        state   <= RX_IDLE;
                     end
                  end
                  default: state <= RX_IDLE;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/ovs_uart_rx.sv
module ovs_uart_rx
   import ovs_rx_pkg::*;
#(
   parameter int OSR        = 16,
   parameter int VER_A      = 3,
   parameter int VER_B      = 5,
   parameter int VER_C      = 7,
   parameter int CTR_SLOT   = 8,
   parameter int SHORT_BITS = 8,
   parameter int LONG_BITS  = 9
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 tick16_i,
   input  logic                 rxd_i,
   input  logic                 long_frame_i,
   output logic [LONG_BITS-1:0] rx_data_o,
   output logic                 rx_valid_o,
   output logic                 rx_noise_o,
   output logic                 rx_ferr_o
);

   localparam int N_VOTERS = 2;

   logic [N_VOTERS-1:0][VOTE_N-1:0] sets;
   logic [N_VOTERS-1:0]             maj, mix;

   ovs_rx_seq #(
      .OSR(OSR), .VER_A(VER_A), .VER_B(VER_B), .VER_C(VER_C),
      .CTR_SLOT(CTR_SLOT), .SHORT_BITS(SHORT_BITS), .LONG_BITS(LONG_BITS)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick16_i),
      .rxd_i       (rxd_i),
      .long_i      (long_frame_i),
      .ver_set_o   (sets[0]),
      .ctr_set_o   (sets[1]),
      .ver_maj_i   (maj[0]),
      .ver_mixed_i (mix[0]),
      .ctr_maj_i   (maj[1]),
      .ctr_mixed_i (mix[1]),
      .data_o      (rx_data_o),
      .valid_o     (rx_valid_o),
      .noise_o     (rx_noise_o),
      .ferr_o      (rx_ferr_o)
   );

   genvar g;
   generate
      for (g = 0; g < N_VOTERS; g++) begin : g_vote
         ovs_rx_vote u_vote (
            .smp_i   (sets[g]),
            .maj_o   (maj[g]),
            .mixed_o (mix[g])
         );
      end
   endgenerate

endmodule

// File: rtl/ovs_uart_rx_chk.sv
module ovs_uart_rx_chk #(
   parameter int DW = 9
)(
   input logic          clk,
   input logic          rst_n,
   input logic          tick_i,
   input logic          valid_i,
   input logic          noise_i,
   input logic          ferr_i,
   input logic [DW-1:0] data_i
);

   // R8: the strobe lasts a single clock
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> !valid_i);

   // R8: the word changes only together with a delivery
   a_r8_data_held: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |-> $stable(data_i));

   // R9: flags are zero outside a delivery
   a_r9_flags_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |-> (!noise_i && !ferr_i));

   // R12: a delivery follows a clock that carried a strobe
   a_r12_valid_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_i) |-> $past(tick_i));

endmodule

bind ovs_uart_rx ovs_uart_rx_chk #(.DW(LONG_BITS)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .tick_i  (tick16_i),
   .valid_i (rx_valid_o),
   .noise_i (rx_noise_o),
   .ferr_i  (rx_ferr_o),
   .data_i  (rx_data_o)
);

// File: tb/sim_ovs_uart_rx.sv
module sim_ovs_uart_rx;

   localparam int CLK_PERIOD = 10;
   localparam int DW         = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic          rxd = 1'b1;
   logic          longf = 1'b0;
   logic [DW-1:0] data;
   logic          valid, noise, ferr;

   always #(CLK_PERIOD/2) clk = ~clk;

   ovs_uart_rx u0 (
      .clk(clk), .rst_n(rst_n), .tick16_i(tick), .rxd_i(rxd),
      .long_frame_i(longf), .rx_data_o(data), .rx_valid_o(valid),
      .rx_noise_o(noise), .rx_ferr_o(ferr)
   );

   bit    line_q[$];
   bit    len_q[$];
   int    exp_data[int];
   bit    exp_noise[int];
   bit    exp_fe[int];
   string exp_tag[int];
   int    checks = 0;
   int    errors = 0;
   bit    done = 0;

   task automatic push_lvl(bit v, int n);
      repeat (n) begin
         line_q.push_back(v);
         len_q.push_back(1'b0);
      end
   endtask

   // flips are coded as bit*16+slot, bit 0 = start bit; -1 means none
   task automatic push_frame(int d, bit nine, bit stop, int f0, int f1, int f2,
                             int low_after, string tag);
      int n, base, key, code;
      bit v, nz;
      n    = nine ? 9 : 8;
      base = line_q.size();
      nz   = 1'b0;
      for (int b = 0; b < n + 2; b++) begin
         for (int s = 1; s <= 16; s++) begin
            v    = (b == 0) ? 1'b0 : (b == n + 1) ? stop : d[b-1];
            code = b * 16 + s;
            if (code == f0 || code == f1 || code == f2) begin
               v = !v;
               if ((s >= 8 && s <= 10) || (b == 0 && (s == 3 || s == 5 || s == 7)))
                  nz = 1'b1;
            end
            line_q.push_back(v);
            len_q.push_back((b == 0 && s == 1) ? nine : !nine);
         end
      end
      key           = base + 16 * (n + 1) + 9;
      exp_data[key] = d & (nine ? 32'h1FF : 32'h0FF);
      exp_noise[key]= nz;
      exp_fe[key]   = !stop;
      exp_tag[key]  = tag;
      if (!stop) push_lvl(1'b0, low_after);
   endtask

   task automatic do_check(bit e, int key);
      checks++;
      if (e) begin
         if (valid !== 1'b1 || data !== DW'(exp_data[key]) ||
             noise !== exp_noise[key] || ferr !== exp_fe[key]) begin
            errors++;
            $display("FAIL %s R8 tick %0d: valid=%b data=%h noise=%b ferr=%b, expected valid=1 data=%h noise=%b ferr=%b",
                     exp_tag[key], key, valid, data, noise, ferr,
                     DW'(exp_data[key]), exp_noise[key], exp_fe[key]);
         end
      end else if (valid !== 1'b0 || noise !== 1'b0 || ferr !== 1'b0) begin
         errors++;
         $display("FAIL R9 idle cycle: valid=%b noise=%b ferr=%b, expected 0 0 0",
                  valid, noise, ferr);
      end
   endtask

   initial begin : main
      bit pend;
      int pend_key;
      pend = 1'b0;
      pend_key = 0;
      repeat (3) @(negedge clk);
      checks++;
      if (valid !== 1'b0 || data !== '0 || noise !== 1'b0 || ferr !== 1'b0) begin
         errors++;
         $display("FAIL R1 reset: valid=%b data=%h noise=%b ferr=%b, expected all zero",
                  valid, data, noise, ferr);
      end
      rst_n = 1'b1;

      // R1: line low from reset must not start a frame
      push_lvl(1'b0, 5);
      push_lvl(1'b1, 20);
      push_frame(32'h05A, 1'b0, 1'b1, -1, -1, -1, 0, "R6");
      push_lvl(1'b1, 7);
      push_frame(32'h1A5, 1'b1, 1'b1, -1, -1, -1, 0, "R7");
      push_lvl(1'b1, 12);
      push_frame(32'h03C, 1'b0, 1'b1, 3, -1, -1, 0, "R3");
      push_lvl(1'b1, 5);
      push_frame(32'h081, 1'b0, 1'b1, 4*16+9, -1, -1, 0, "R5");
      push_lvl(1'b1, 5);
      push_frame(32'h00F, 1'b0, 1'b1, 1*16+2, 2*16+6, 5*16+12, 0, "R4");
      push_lvl(1'b1, 5);
      push_frame(32'h066, 1'b0, 1'b0, -1, -1, -1, 40, "R10");
      push_lvl(1'b1, 10);
      push_frame(32'h011, 1'b0, 1'b1, -1, -1, -1, 0, "R11");
      push_frame(32'h1EE, 1'b1, 1'b1, -1, -1, -1, 0, "R11");
      push_frame(32'h100, 1'b1, 1'b1, 10*16+10, -1, -1, 0, "R5");
      push_lvl(1'b1, 3);
      push_frame(32'h0A5, 1'b0, 1'b1, 8, -1, -1, 0, "R5");
      // R2: a one-slot glitch, a four-slot pulse, and samples 1/0/1 at 3/5/7
      push_lvl(1'b1, 10);
      push_lvl(1'b0, 1);
      push_lvl(1'b1, 30);
      push_lvl(1'b0, 4);
      push_lvl(1'b1, 30);
      push_lvl(1'b0, 2);
      push_lvl(1'b1, 1);
      push_lvl(1'b0, 2);
      push_lvl(1'b1, 30);
      push_frame(32'h0C3, 1'b0, 1'b1, 5, -1, -1, 0, "R3");
      push_lvl(1'b1, 20);

      for (int k = 0; k < line_q.size(); k++) begin
         @(negedge clk);
         do_check(pend, pend_key);
         pend     = exp_data.exists(k);
         pend_key = k;
         rxd      = line_q[k];
         longf    = len_q[k];
         tick     = 1'b1;
         for (int g = 0; g < k % 3; g++) begin
            @(negedge clk);
            do_check(pend, pend_key);
            pend = 1'b0;
            tick = 1'b0;
         end
      end
      @(negedge clk);
      do_check(pend, pend_key);
      tick = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         do_check(1'b0, 0);
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule